// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Acknowledge Unit

This block joins two eight-line interrupt arbitration units into one sixteen-line controller. Request lines 0 to 7 feed the primary unit and lines 8 to 15 feed the secondary unit; bit 3 of a line number picks the unit. The secondary unit's "grant pending" output takes the place of primary line 2, so every secondary request reaches the processor through that line. The processor interrupt output is high whenever the primary unit holds a grant.

When the processor pulses the acknowledge strobe, the block works out which unit grants. It acknowledges the primary unit and, when the grant passes through line 2, the secondary unit as well. It then forms an eight-bit vector from the granting unit's base and the granted line. If a unit has nothing to grant at acknowledge time, the grant is spurious. The vector then carries line 7 of that unit, and that unit is not acknowledged. The vector is registered and appears one cycle after the strobe, together with a one-cycle valid pulse.

Each unit has a small built-in resolver. A masked request is never granted. The lowest line number has the highest priority. A line in service blocks itself and every lower-priority line until an end-of-service strobe clears the highest-priority line in service. Each unit also holds a trigger-mode register that selects edge or level capture for each line. Writes to that register pass through a fixed mask, and only hardware reset clears it.

Top module: `cascade_ack_ctrl`

## Requirements
- R1: After reset, `vec_valid` and `cpu_int` are 0 and both trigger-mode outputs `tm_pri` and `tm_sec` read 0x00.
- R2: Lines 8 to 15 reach `cpu_int` only through primary line 2. A secondary edge request sampled at clock edge E1 is captured by the secondary unit at E1 and by the primary unit at E2, so `cpu_int` is 0 after E1 and 1 after E2. `irq_in[2]` has no effect.
- R3: `vec_valid` is 1 for exactly the one cycle after a cycle in which `inta` is high. In that cycle, `vec` holds the vector of that acknowledge.
- R4: If the primary unit grants line n other than 2, the vector is {`base_pri`[7:3], n} and the primary unit is acknowledged.
- R5: If the primary unit grants line 2 and the secondary unit grants line m, the vector is {`base_sec`[7:3], m} and both units are acknowledged.
- R6: If the primary unit grants line 2 while the secondary unit has no grant, the vector is {`base_sec`[7:3], 3'd7} and the secondary unit is not acknowledged, so a later request on line 15 still raises `cpu_int`.
- R7: If the primary unit has no grant at acknowledge time, the vector is {`base_pri`[7:3], 3'd7} and the primary unit is not acknowledged, so a later request on line 7 still raises `cpu_int`.
- R8: A write with `tm_we`=1 stores `tm_wdata` AND 0xF8 into the primary trigger-mode register when `tm_sel`=0, or `tm_wdata` AND 0xDE into the secondary one when `tm_sel`=1. The stored values read back on `tm_pri` and `tm_sec`. Only reset clears them.
- R9: Priority: the lowest pending unmasked line number wins, but only if it is lower than every line in service. An acknowledge puts the granted line in service. Each `eoi_pri` or `eoi_sec` pulse removes the lowest-numbered line in service from its unit.
- R10: A trigger-mode bit of 0 selects edge capture: a rising edge sets the request, and only its acknowledge clears it. A bit of 1 selects level capture: the request follows the input line, and an acknowledge does not clear it.
- R11: A line whose bit is 1 in `mask_pri` or `mask_sec` is not granted and does not raise `cpu_int`. Clearing that mask bit releases the request the unit is already holding.
- R12: `cpu_int` is 1 exactly when the primary unit holds a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_in | input | 16 | Request lines; bits 7:0 primary, 15:8 secondary; bit 2 unused |
| mask_pri | input | 8 | Primary mask, 1 blocks a line |
| mask_sec | input | 8 | Secondary mask, 1 blocks a line |
| base_pri | input | 8 | Primary vector base, bits 7:3 used |
| base_sec | input | 8 | Secondary vector base, bits 7:3 used |
| eoi_pri | input | 1 | Primary end-of-service strobe |
| eoi_sec | input | 1 | Secondary end-of-service strobe |
| inta | input | 1 | Processor acknowledge strobe, one cycle |
| tm_we | input | 1 | Trigger-mode write enable |
| tm_sel | input | 1 | 0 primary, 1 secondary register |
| tm_wdata | input | 8 | Trigger-mode write data |
| tm_pri | output | 8 | Primary trigger-mode register |
| tm_sec | output | 8 | Secondary trigger-mode register |
| cpu_int | output | 1 | Processor interrupt request |
| vec_valid | output | 1 | Vector valid pulse |
| vec | output | 8 | Acknowledge vector |

## Verification
The assertions assume that `inta` is a single-cycle strobe, with at least one idle cycle between strobes. They also assume that the end-of-service strobes are never raised in the same cycle as an acknowledge. The bench keeps to this by spacing every strobe with idle cycles and by raising each end-of-service pulse on its own. Line changes are applied only at falling edges and are held for several cycles, so each request settles in both units before the acknowledge samples it. The spurious cases are produced by dropping a level-captured request after it has already reached the primary unit's edge capture on line 2, or reached the processor.

// File: rtl/cascade_ack_pkg.sv
package cascade_ack_pkg;
  localparam int unsigned UNIT_LINES = 8;
  localparam int unsigned IDX_W      = $clog2(UNIT_LINES);
  localparam int unsigned PRI_W      = IDX_W + 1;
  localparam int unsigned VEC_W      = 8;

  typedef logic [IDX_W-1:0]      line_idx_t;
  typedef logic [UNIT_LINES-1:0] line_vec_t;
  typedef logic [PRI_W-1:0]      pri_t;
  typedef logic [VEC_W-1:0]      vec_t;
endpackage

// File: rtl/cac_unit.sv
module cac_unit
  import cascade_ack_pkg::*;
#(
  parameter line_vec_t TM_MASK = '1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t req_in,
  input  line_vec_t mask,
  input  logic      eoi,
  input  logic      ack,
  input  line_idx_t ack_idx,
  input  logic      tm_we,
  input  line_vec_t tm_wdata,
  output line_vec_t tm_q,
  output logic      grant_vld,
  output line_idx_t grant_idx
);

  line_vec_t req_q, irr_q, isr_q;
  line_vec_t irr_d, isr_d, tm_d;
  line_vec_t ack_oh, eoi_oh, pend;
  pri_t      pend_pri, isr_pri;

  assign pend = irr_q & ~mask;

  always_comb begin
    pend_pri = pri_t'(UNIT_LINES);
    for (int i = UNIT_LINES - 1; i >= 0; i--) begin
      if (pend[i]) pend_pri = pri_t'(i);
    end
  end

  always_comb begin
    isr_pri = pri_t'(UNIT_LINES);
    for (int i = UNIT_LINES - 1; i >= 0; i--) begin
      if (isr_q[i]) isr_pri = pri_t'(i);
    end
  end

  assign grant_vld = (pend_pri < isr_pri);
  assign grant_idx = pend_pri[IDX_W-1:0];

  always_comb begin
    ack_oh = '0;
    if (ack) ack_oh[ack_idx] = 1'b1;
    eoi_oh = '0;
    if (eoi && (isr_pri < pri_t'(UNIT_LINES))) eoi_oh[isr_pri[IDX_W-1:0]] = 1'b1;
  end

  for (genvar g = 0; g < UNIT_LINES; g++) begin : g_line
    assign irr_d[g] = tm_q[g] ? req_in[g]
                              : ((irr_q[g] & ~ack_oh[g]) | (req_in[g] & ~req_q[g]));
  end

  assign isr_d = (isr_q | ack_oh) & ~eoi_oh;
  assign tm_d  = tm_wdata & TM_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      irr_q <= '0;
      isr_q <= '0;
      tm_q  <= '0;
    end else begin
      req_q <= req_in;
      irr_q <= irr_d;
      isr_q <= isr_d;
      if (tm_we) tm_q <= tm_d;
    end
  end

  // R9: an acknowledge always targets the line this unit grants
  a_r9_ack_is_grant : assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (grant_vld && (ack_idx == grant_idx)));

  // R9: the acknowledged line is in service afterwards
  a_r9_ack_in_service : assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !eoi) |=> isr_q[$past(ack_idx)]);

  // R10: a level line still driven stays requested after its acknowledge
  a_r10_level_survives_ack : assert property (@(posedge clk) disable iff (!rst_n)
    (ack && tm_q[ack_idx] && req_in[ack_idx] && !tm_we) |=> irr_q[$past(ack_idx)]);

endmodule

// File: rtl/cac_steer.sv
module cac_steer
  import cascade_ack_pkg::*;
#(
  parameter line_idx_t CAS_LINE = line_idx_t'(2)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inta,
  input  logic      pri_vld,
  input  line_idx_t pri_idx,
  input  logic      sec_vld,
  input  line_idx_t sec_idx,
  input  vec_t      base_pri,
  input  vec_t      base_sec,
  output logic      pri_ack,
  output logic      sec_ack,
  output logic      vec_vld,
  output vec_t      vec
);

  localparam line_idx_t SPUR_LINE = '1;

  vec_t vec_d;
  logic unused_base_low;

  assign unused_base_low = ^{base_pri[IDX_W-1:0], base_sec[IDX_W-1:0]};

  always_comb begin
    pri_ack = 1'b0;
    sec_ack = 1'b0;
    vec_d   = {base_pri[VEC_W-1:IDX_W], SPUR_LINE};
    if (inta && pri_vld) begin
      pri_ack = 1'b1;
      if (pri_idx == CAS_LINE) begin
        if (sec_vld) begin
          sec_ack = 1'b1;
          vec_d   = {base_sec[VEC_W-1:IDX_W], sec_idx};
        end else begin
          vec_d   = {base_sec[VEC_W-1:IDX_W], SPUR_LINE};
        end
      end else begin
        vec_d = {base_pri[VEC_W-1:IDX_W], pri_idx};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_vld <= 1'b0;
      vec     <= '0;
    end else begin
      vec_vld <= inta;
      if (inta) vec <= vec_d;
    end
  end

  // R3: one valid pulse follows each strobe
  a_r3_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> vec_vld);

  // R3: no valid without a strobe
  a_r3_no_stray_valid : assert property (@(posedge clk) disable iff (!rst_n)
    !inta |=> !vec_vld);

  // R6: cascade grant with an empty secondary yields line 7, no secondary ack
  a_r6_spurious_sec : assert property (@(posedge clk) disable iff (!rst_n)
    (inta && pri_vld && (pri_idx == CAS_LINE) && !sec_vld)
      |=> (vec[IDX_W-1:0] == SPUR_LINE) && !$past(sec_ack));

  // R7: no primary grant means no primary acknowledge
  a_r7_no_pri_ack : assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !pri_vld) |-> !pri_ack);

endmodule

// File: rtl/cascade_ack_ctrl.sv
module cascade_ack_ctrl
  import cascade_ack_pkg::*;
#(
  parameter line_idx_t CAS_LINE    = line_idx_t'(2),
  parameter line_vec_t PRI_TM_MASK = line_vec_t'(8'hF8),
  parameter line_vec_t SEC_TM_MASK = line_vec_t'(8'hDE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2*UNIT_LINES-1:0] irq_in,
  input  logic [UNIT_LINES-1:0]   mask_pri,
  input  logic [UNIT_LINES-1:0]   mask_sec,
  input  logic [VEC_W-1:0]        base_pri,
  input  logic [VEC_W-1:0]        base_sec,
  input  logic                    eoi_pri,
  input  logic                    eoi_sec,
  input  logic                    inta,
  input  logic                    tm_we,
  input  logic                    tm_sel,
  input  logic [UNIT_LINES-1:0]   tm_wdata,
  output logic [UNIT_LINES-1:0]   tm_pri,
  output logic [UNIT_LINES-1:0]   tm_sec,
  output logic                    cpu_int,
  output logic                    vec_valid,
  output logic [VEC_W-1:0]        vec
);

  logic      rst_s1, rst_sn;
  logic      pri_vld, sec_vld, pri_ack, sec_ack;
  line_idx_t pri_idx, sec_idx;
  line_vec_t pri_req;
  logic      unused_cas_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  assign unused_cas_in = irq_in[CAS_LINE];

  always_comb begin
    pri_req           = irq_in[UNIT_LINES-1:0];
    pri_req[CAS_LINE] = sec_vld;
  end

  cac_unit #(.TM_MASK(PRI_TM_MASK)) i_pri (
    .clk       (clk),
    .rst_n     (rst_sn),
    .req_in    (pri_req),
    .mask      (mask_pri),
    .eoi       (eoi_pri),
    .ack       (pri_ack),
    .ack_idx   (pri_idx),
    .tm_we     (tm_we & ~tm_sel),
    .tm_wdata  (tm_wdata),
    .tm_q      (tm_pri),
    .grant_vld (pri_vld),
    .grant_idx (pri_idx)
  );

  cac_unit #(.TM_MASK(SEC_TM_MASK)) i_sec (
    .clk       (clk),
    .rst_n     (rst_sn),
    .req_in    (irq_in[2*UNIT_LINES-1:UNIT_LINES]),
    .mask      (mask_sec),
    .eoi       (eoi_sec),
    .ack       (sec_ack),
    .ack_idx   (sec_idx),
    .tm_we     (tm_we & tm_sel),
    .tm_wdata  (tm_wdata),
    .tm_q      (tm_sec),
    .grant_vld (sec_vld),
    .grant_idx (sec_idx)
  );

  cac_steer #(.CAS_LINE(CAS_LINE)) i_steer (
    .clk      (clk),
    .rst_n    (rst_sn),
    .inta     (inta),
    .pri_vld  (pri_vld),
    .pri_idx  (pri_idx),
    .sec_vld  (sec_vld),
    .sec_idx  (sec_idx),
    .base_pri (base_pri),
    .base_sec (base_sec),
    .pri_ack  (pri_ack),
    .sec_ack  (sec_ack),
    .vec_vld  (vec_valid),
    .vec      (vec)
  );

  assign cpu_int = pri_vld;

  // R5: the secondary is only acknowledged through the primary's cascade line
  a_r5_sec_ack_via_cascade : assert property (@(posedge clk) disable iff (!rst_sn)
    sec_ack |-> (pri_ack && (pri_idx == CAS_LINE)));

endmodule

// File: tb/test_cascade_ack_ctrl.sv
module test_cascade_ack_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_in;
  logic [7:0]  mask_pri, mask_sec, base_pri, base_sec, tm_wdata;
  logic        eoi_pri, eoi_sec, inta, tm_we, tm_sel;
  logic [7:0]  tm_pri, tm_sec, vec;
  logic        cpu_int, vec_valid;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_ack_ctrl i_cascade_ack_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_pri(mask_pri), .mask_sec(mask_sec),
    .base_pri(base_pri), .base_sec(base_sec), .eoi_pri(eoi_pri), .eoi_sec(eoi_sec),
    .inta(inta), .tm_we(tm_we), .tm_sel(tm_sel), .tm_wdata(tm_wdata),
    .tm_pri(tm_pri), .tm_sec(tm_sec), .cpu_int(cpu_int), .vec_valid(vec_valid), .vec(vec)
  );

  // {lines, expected vector}
  localparam logic [23:0] VEC_TBL [0:7] = '{
    {16'h0001, 8'h08},  // R4 line 0
    {16'h0020, 8'h0D},  // R4 line 5
    {16'h0028, 8'h0B},  // R4 line 3 beats 5
    {16'h0100, 8'h70},  // R5 line 8
    {16'h8000, 8'h77},  // R5 line 15
    {16'h0A00, 8'h71},  // R5 line 9 beats 11
    {16'h0102, 8'h09},  // R4 line 1 beats cascade
    {16'h0108, 8'h70}   // R5 cascade beats line 3
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    irq_in = '0; mask_pri = '0; mask_sec = '0; base_pri = 8'h08; base_sec = 8'h70;
    eoi_pri = 0; eoi_sec = 0; inta = 0; tm_we = 0; tm_sel = 0; tm_wdata = '0;
    rst_n = 0;
    step(2);
    rst_n = 1;
    step(3);
  endtask

  task automatic pulse_inta();
    inta = 1;
    step(1);
    inta = 0;
  endtask

  task automatic pulse_eoi_pri();
    eoi_pri = 1;
    step(1);
    eoi_pri = 0;
  endtask

  task automatic tm_write(input logic sel, input logic [7:0] d);
    tm_we = 1; tm_sel = sel; tm_wdata = d;
    step(1);
    tm_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R3 actual hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
    chk("R1 cpu_int", {7'd0, cpu_int}, 8'h00);
    chk("R1 tm_pri", tm_pri, 8'h00);
    chk("R1 tm_sec", tm_sec, 8'h00);

    // R4 / R5 / R3 vector table
    for (int k = 0; k < 8; k++) begin
      do_reset();
      irq_in = VEC_TBL[k][23:8];
      step(4);
      chk("R12 cpu_int before ack", {7'd0, cpu_int}, 8'h01);
      pulse_inta();
      chk("R3 valid pulse", {7'd0, vec_valid}, 8'h01);
      chk("R4_R5 vector", vec, VEC_TBL[k][7:0]);
      step(1);
      chk("R3 valid single cycle", {7'd0, vec_valid}, 8'h00);
    end

    // R8 trigger-mode masks
    do_reset();
    tm_write(1'b0, 8'hFF);
    chk("R8 primary mask", tm_pri, 8'hF8);
    tm_write(1'b1, 8'hFF);
    chk("R8 secondary mask", tm_sec, 8'hDE);
    chk("R8 primary kept", tm_pri, 8'hF8);
    do_reset();
    chk("R1 tm_pri cleared", tm_pri, 8'h00);
    chk("R1 tm_sec cleared", tm_sec, 8'h00);

    // R2 cascade latency and unused line 2 input
    do_reset();
    irq_in[2] = 1;
    step(3);
    chk("R2 line2 input ignored", {7'd0, cpu_int}, 8'h00);
    irq_in[8] = 1;
    step(1);
    chk("R2 after first edge", {7'd0, cpu_int}, 8'h00);
    step(1);
    chk("R2 after second edge", {7'd0, cpu_int}, 8'h01);

    // R11 mask
    do_reset();
    mask_pri = 8'h20;
    irq_in[5] = 1;
    step(3);
    chk("R11 masked", {7'd0, cpu_int}, 8'h00);
    mask_pri = 8'h00;
    step(1);
    chk("R11 unmasked", {7'd0, cpu_int}, 8'h01);

    // R9 nesting
    do_reset();
    irq_in[5] = 1;
    step(2);
    pulse_inta();
    chk("R9 first grant", vec, 8'h0D);
    irq_in[6] = 1;
    step(2);
    chk("R9 lower blocked", {7'd0, cpu_int}, 8'h00);
    irq_in[3] = 1;
    step(2);
    chk("R9 higher preempts", {7'd0, cpu_int}, 8'h01);
    pulse_inta();
    chk("R9 preempt vector", vec, 8'h0B);
    pulse_eoi_pri();
    step(1);
    chk("R9 still blocked by 5", {7'd0, cpu_int}, 8'h00);
    pulse_eoi_pri();
    step(1);
    chk("R9 released", {7'd0, cpu_int}, 8'h01);
    pulse_inta();
    chk("R9 line 6 vector", vec, 8'h0E);

    // R10 level and edge capture
    do_reset();
    tm_write(1'b0, 8'h08);
    irq_in[3] = 1;
    step(2);
    pulse_inta();
    chk("R10 level vector", vec, 8'h0B);
    pulse_eoi_pri();
    step(1);
    chk("R10 level held after ack", {7'd0, cpu_int}, 8'h01);
    irq_in[3] = 0;
    step(1);
    chk("R10 level follows input", {7'd0, cpu_int}, 8'h00);
    irq_in[4] = 1;
    step(2);
    pulse_inta();
    chk("R10 edge vector", vec, 8'h0C);
    pulse_eoi_pri();
    step(1);
    chk("R10 edge cleared by ack", {7'd0, cpu_int}, 8'h00);

    // R6 spurious secondary
    do_reset();
    tm_write(1'b1, 8'h02);
    irq_in[9] = 1;
    step(3);
    irq_in[9] = 0;
    step(2);
    chk("R6 cascade still pending", {7'd0, cpu_int}, 8'h01);
    pulse_inta();
    chk("R6 spurious vector", vec, 8'h77);
    pulse_eoi_pri();
    irq_in[15] = 1;
    step(3);
    chk("R6 secondary not acked", {7'd0, cpu_int}, 8'h01);

    // R7 spurious primary
    do_reset();
    tm_write(1'b0, 8'h08);
    irq_in[3] = 1;
    step(2);
    irq_in[3] = 0;
    step(1);
    chk("R7 request gone", {7'd0, cpu_int}, 8'h00);
    pulse_inta();
    chk("R7 spurious vector", vec, 8'h0F);
    irq_in[7] = 1;
    step(2);
    chk("R7 primary not acked", {7'd0, cpu_int}, 8'h01);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule